// File: doc/BRIEF.md
# Self-Checking Mealy Controller with Weight-Coded State

This block is a small Mealy state machine built so that it reports its own hardware faults while it runs. Every state is stored as a fixed-weight word, meaning each legal state has exactly `M_HOT` ones in an `N_BITS`-wide register. Every output word carries Berger check bits: the binary ones count of the information bits, inverted. Past the input inverters, the next-state and output logic is built only from AND and OR terms. A present state is recognised by testing only its 1 bits, so the logic is unate in the state variables, and a stuck line inside it can push the outputs in one direction only.

Two embedded checkers watch the machine. A weight checker monitors the next-state lines and a Berger checker monitors the encoded output word. Each produces a two-rail pair, and a two-rail cell merges the two pairs into one alarm pair `z_o`. A complementary alarm pair (01 or 10) means healthy. An equal pair (00 or 11) means a noncodeword was seen.

A fault-injection port can force any next-state line or output bit to a chosen value, so that the detection path can be exercised. The primary input is assumed to be checked upstream.

Top module: `scfsm_top`

## Requirements
- R1: While `rst_i` is high, the state register loads the first weight-`M_HOT` code, state S0. After reset with `x_i`=0, `out_o` reads 4'b1100: check bits `out_o[3:2]`=11 and information bits `out_o[1:0]`=00.
- R2: State codes are the weight-`M_HOT` words of `N_BITS` bits, taken in ascending numeric order for S0..S3. With the default `M_HOT`=1 they are 0001, 0010, 0100 and 1000. With no injection, the register always holds exactly `M_HOT` ones.
- R3: Transitions (state, x -> next state): S0,0->S0; S0,1->S1; S1,0->S2; S1,1->S0; S2,0->S3; S2,1->S2; S3,0->S0; S3,1->S1.
- R4: Information bits `out_o[1:0]` (state, x -> info): S0,0->00; S0,1->01; S1,0->10; S1,1->01; S2,0->11; S2,1->00; S3,0->10; S3,1->11.
- R5: Check bits `out_o[3:2]` equal the bitwise inverse of the 2-bit ones count of `out_o[1:0]`. So info with no ones gives 11, info with one 1 gives 10, and info with two ones gives 01.
- R6: With no injection and a legal state, `z_o` is complementary (01 or 10).
- R7: When the next-state lines (after injection) hold a number of ones other than `M_HOT`, `z_o` is 00 or 11.
- R8: When the output word's check bits do not match the Berger code of its information bits, `z_o` is 00 or 11.
- R9: Injection bits `fi_mask_i[N_BITS-1:0]` force next-state line i, and bits `fi_mask_i[N_BITS+j]` force `out_o[j]`, each to the matching bit of `fi_val_i`. A forced next-state value is captured by the register at the clock edge.
- R10: A stored state with extra ones activates every state whose ones it covers, and the output words of those states are ORed. For example, state 0011 with x=0 gives `out_o`=1110. A stored state of all zeros gives `out_o`=0000. Both are flagged by an equal `z_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| x_i | input | 1 | Primary input bit |
| fi_mask_i | input | N_BITS+4 | Per-bit force enable: low bits are next-state lines, upper four are output bits |
| fi_val_i | input | N_BITS+4 | Value forced where the mask is set |
| out_o | output | 4 | Encoded output: [3:2] Berger check bits, [1:0] information bits |
| z_o | output | 2 | Two-rail alarm pair, complementary when healthy |

## Verification
On every cycle, the assertions check four things: that the reset code is loaded, that the register keeps its weight while no fault is forced, that check bits match information bits on a healthy machine, and that any weight or Berger violation turns the alarm pair equal. Only the bench scenarios can show the actual transition and output table, in a directed walk and a long pseudo-random input sequence compared against a reference model. The same holds for each single stuck-at-0 and stuck-at-1 on every next-state and output bit, which must raise the alarm exactly when the forced value differs from the good one. It also holds for the covered-state decoding after a multi-hot or all-zero state is forced into the register.

// File: rtl/scfsm_pkg.sv
package scfsm_pkg;

    localparam int NUM_ST = 4;
    localparam int INFO_W = 2;
    localparam int CHK_W  = $clog2(INFO_W + 1);
    localparam int OUT_W  = INFO_W + CHK_W;

    // transition table: next state index
    function automatic int tbl_next(int s, int x);
        int r;
        case (s)
            0:       r = (x != 0) ? 1 : 0;
            1:       r = (x != 0) ? 0 : 2;
            2:       r = (x != 0) ? 2 : 3;
            default: r = (x != 0) ? 1 : 0;
        endcase
        return r;
    endfunction

    // transition table: information bits
    function automatic logic [INFO_W-1:0] tbl_info(int s, int x);
        logic [INFO_W-1:0] r;
        case (s)
            0:       r = (x != 0) ? 2'b01 : 2'b00;
            1:       r = (x != 0) ? 2'b01 : 2'b10;
            2:       r = (x != 0) ? 2'b00 : 2'b11;
            default: r = (x != 0) ? 2'b11 : 2'b10;
        endcase
        return r;
    endfunction

    // inverted ones count of the information bits
    function automatic logic [CHK_W-1:0] berger_of(logic [INFO_W-1:0] v);
        logic [CHK_W-1:0] c;
        c = '0;
        for (int i = 0; i < INFO_W; i++) begin
            c = c + CHK_W'(v[i]);
        end
        return ~c;
    endfunction

    // idx-th word of width n holding exactly m ones, ascending order
    function automatic logic [31:0] code_word(int n, int m, int idx);
        logic [31:0] r;
        int          seen;
        r    = '0;
        seen = 0;
        for (int v = 0; v < (1 << n); v++) begin
            if ($countones(v) == m) begin
                if (seen == idx) begin
                    r = 32'(v);
                end
                seen++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/scfsm_trc2.sv
module scfsm_trc2 (
    input  logic [1:0] a_i,
    input  logic [1:0] b_i,
    output logic [1:0] z_o
);
    // complementary in, complementary out; any equal pair propagates
    always_comb begin
        z_o[1] = (a_i[1] & b_i[1]) | (a_i[0] & b_i[0]);
        z_o[0] = (a_i[1] & b_i[0]) | (a_i[0] & b_i[1]);
    end
endmodule

// File: rtl/scfsm_weight_chk.sv
module scfsm_weight_chk #(
    parameter int N_BITS = 4,
    parameter int M_HOT  = 1
) (
    input  logic [N_BITS-1:0] word_i,
    output logic [1:0]        rail_o
);
    localparam int CW = $clog2(N_BITS + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N_BITS; i++) begin
            cnt = cnt + CW'(word_i[i]);
        end
        // exact weight -> 10, light -> 00, heavy -> 11
        rail_o[1] = (cnt >= CW'(M_HOT));
        rail_o[0] = (cnt >  CW'(M_HOT));
    end
endmodule

// File: rtl/scfsm_berger_chk.sv
module scfsm_berger_chk
    import scfsm_pkg::*;
(
    input  logic [OUT_W-1:0] word_i,
    output logic [1:0]       rail_o
);
    logic [CHK_W-1:0] expect_c;
    logic [1:0]       pair [CHK_W];
    logic [1:0]       acc  [CHK_W];

    assign expect_c = berger_of(word_i[INFO_W-1:0]);

    genvar j;
    generate
        for (j = 0; j < CHK_W; j++) begin : g_pair
            assign pair[j] = {expect_c[j], ~word_i[INFO_W+j]};
            if (j == 0) begin : g_first
                assign acc[j] = pair[j];
            end else begin : g_chain
                scfsm_trc2 u_trc (
                    .a_i(acc[j-1]),
                    .b_i(pair[j]),
                    .z_o(acc[j])
                );
            end
        end
    endgenerate

    assign rail_o = acc[CHK_W-1];
endmodule

// File: rtl/scfsm_top.sv
module scfsm_top
    import scfsm_pkg::*;
#(
    parameter int N_BITS = 4,
    parameter int M_HOT  = 1
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    x_i,
    input  logic [N_BITS+OUT_W-1:0] fi_mask_i,
    input  logic [N_BITS+OUT_W-1:0] fi_val_i,
    output logic [OUT_W-1:0]        out_o,
    output logic [1:0]              z_o
);
    typedef struct packed {
        logic [N_BITS-1:0] st;
    } regs_t;

    regs_t reg_d, reg_q;

    logic [N_BITS-1:0] code_tbl [NUM_ST];
    logic [N_BITS-1:0] ns_tbl   [NUM_ST][2];
    logic [OUT_W-1:0]  ow_tbl   [NUM_ST][2];
    logic [NUM_ST-1:0] st_hit;
    logic [N_BITS-1:0] ns_raw, ns_line, st_now;
    logic [OUT_W-1:0]  ow_raw;
    logic [1:0]        rail_ns, rail_ow;

    genvar g, xb;
    generate
        for (g = 0; g < NUM_ST; g++) begin : g_code
            localparam logic [31:0] CWORD = code_word(N_BITS, M_HOT, g);
            assign code_tbl[g] = CWORD[N_BITS-1:0];
            for (xb = 0; xb < 2; xb++) begin : g_arc
                localparam int                NXT  = tbl_next(g, xb);
                localparam logic [INFO_W-1:0] INFO = tbl_info(g, xb);
                assign ns_tbl[g][xb] = code_tbl[NXT];
                assign ow_tbl[g][xb] = {berger_of(INFO), INFO};
            end
        end
    endgenerate

    always_comb begin
        reg_d  = reg_q;
        ns_raw = '0;
        ow_raw = '0;
        for (int s = 0; s < NUM_ST; s++) begin
            // only the 1 bits of a state code are tested (unate decode)
            st_hit[s] = &(reg_q.st | ~code_tbl[s]);
            ns_raw = ns_raw | ({N_BITS{st_hit[s] & ~x_i}} & ns_tbl[s][0])
                            | ({N_BITS{st_hit[s] &  x_i}} & ns_tbl[s][1]);
            ow_raw = ow_raw | ({OUT_W{st_hit[s] & ~x_i}} & ow_tbl[s][0])
                            | ({OUT_W{st_hit[s] &  x_i}} & ow_tbl[s][1]);
        end
        ns_line = (ns_raw & ~fi_mask_i[N_BITS-1:0])
                | (fi_val_i[N_BITS-1:0] & fi_mask_i[N_BITS-1:0]);
        out_o   = (ow_raw & ~fi_mask_i[N_BITS+OUT_W-1:N_BITS])
                | (fi_val_i[N_BITS+OUT_W-1:N_BITS] & fi_mask_i[N_BITS+OUT_W-1:N_BITS]);
        reg_d.st = ns_line;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            reg_q.st <= code_tbl[0];
        end else begin
            reg_q <= reg_d;
        end
    end

    assign st_now = reg_q.st;

    scfsm_weight_chk #(.N_BITS(N_BITS), .M_HOT(M_HOT)) u_wchk (
        .word_i(ns_line),
        .rail_o(rail_ns)
    );

    scfsm_berger_chk u_bchk (
        .word_i(out_o),
        .rail_o(rail_ow)
    );

    scfsm_trc2 u_merge (
        .a_i(rail_ns),
        .b_i(rail_ow),
        .z_o(z_o)
    );

endmodule

// File: rtl/scfsm_sva.sv
module scfsm_sva
    import scfsm_pkg::*;
#(
    parameter int N_BITS = 4,
    parameter int M_HOT  = 1
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic [N_BITS+OUT_W-1:0] fi_mask_i,
    input logic [N_BITS-1:0]       st_now,
    input logic [N_BITS-1:0]       ns_line,
    input logic [OUT_W-1:0]        out_o,
    input logic [1:0]              z_o
);
    localparam logic [31:0] S0_WORD = code_word(N_BITS, M_HOT, 0);

    logic healthy;
    assign healthy = (fi_mask_i == '0) && ($countones(st_now) == M_HOT);

    // R1
    reset_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (st_now == S0_WORD[N_BITS-1:0]));

    // R2
    state_weight_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(healthy) |-> ($countones(st_now) == M_HOT));

    // R5
    berger_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        healthy |-> (out_o[OUT_W-1:INFO_W] == berger_of(out_o[INFO_W-1:0])));

    // R6
    healthy_pair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        healthy |-> (z_o[1] != z_o[0]));

    // R7
    ns_alarm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($countones(ns_line) != M_HOT) |-> (z_o[1] == z_o[0]));

    // R8
    out_alarm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_o[OUT_W-1:INFO_W] != berger_of(out_o[INFO_W-1:0])) |-> (z_o[1] == z_o[0]));

endmodule

bind scfsm_top scfsm_sva #(.N_BITS(N_BITS), .M_HOT(M_HOT)) u_sva (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .fi_mask_i(fi_mask_i),
    .st_now   (st_now),
    .ns_line  (ns_line),
    .out_o    (out_o),
    .z_o      (z_o)
);

// File: tb/scfsm_top_bench.sv
module scfsm_top_bench;

    localparam int NB = 4;
    localparam int FW = NB + 4;

    logic          clk_i = 1'b0;
    logic          rst_i = 1'b1;
    logic          x_i   = 1'b0;
    logic [FW-1:0] fi_mask_i = '0;
    logic [FW-1:0] fi_val_i  = '0;
    logic [3:0]    out_o;
    logic [1:0]    z_o;

    int n_chk  = 0;
    int n_fail = 0;
    int m_st   = 0;
    logic [15:0] lfsr = 16'hACE1;

    int         nxt_t  [4][2];
    logic [1:0] info_t [4][2];
    logic [3:0] code_t [4];

    always #10 clk_i = ~clk_i;

    scfsm_top u_scfsm_top (
        .clk_i(clk_i), .rst_i(rst_i), .x_i(x_i),
        .fi_mask_i(fi_mask_i), .fi_val_i(fi_val_i),
        .out_o(out_o), .z_o(z_o)
    );

    function automatic logic [3:0] enc(logic [1:0] info);
        logic [1:0] c;
        c = 2'(info[0]) + 2'(info[1]);
        return {~c, info};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_alarm(string req, logic want_alarm);
        chk(req, {7'd0, z_o[1] == z_o[0]}, {7'd0, want_alarm});
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        fi_mask_i = '0;
        @(posedge clk_i);
        @(posedge clk_i);
        @(negedge clk_i);
        rst_i = 1'b0;
        m_st  = 0;
    endtask

    // one healthy step: drive at negedge, check mid-low, advance model
    task automatic step(logic x, string req);
        x_i = x;
        #5;
        chk({req, " out"}, {4'd0, out_o}, {4'd0, enc(info_t[m_st][x])});
        chk_alarm({req, " pair R6"}, 1'b0);
        @(posedge clk_i);
        m_st = nxt_t[m_st][x];
        @(negedge clk_i);
    endtask

    task automatic t_reset();
        do_reset();
        x_i = 1'b0;
        #5;
        chk("R1 reset output", {4'd0, out_o}, 8'b0000_1100);
        chk_alarm("R1 reset pair", 1'b0);
        @(negedge clk_i);
    endtask

    task automatic t_walk();
        // S0-1->S1-1->S0-1->S1-0->S2-1->S2-0->S3-0->S0-0->S0, then S3,1
        logic [8:0] seq = 9'b0_0001_0111;
        do_reset();
        for (int i = 0; i < 9; i++) step(seq[i], "R3 R4 R5 walk");
        step(1'b1, "R3 R4 walk");
        step(1'b0, "R3 R4 walk");
        step(1'b0, "R3 R4 walk");
        step(1'b1, "R3 R4 walk S3x1");
        step(1'b0, "R2 walk");
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], "R2 R3 R4 R5 random");
        end
    endtask

    // single stuck-at on each next-state line and output bit
    task automatic t_faults();
        logic [3:0] good_ns, good_ow, got;
        do_reset();
        for (int b = 0; b < FW; b++) begin
            for (int pol = 0; pol < 2; pol++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                x_i = lfsr[0];
                good_ns = code_t[nxt_t[m_st][x_i]];
                good_ow = enc(info_t[m_st][x_i]);
                fi_mask_i = FW'(1) << b;
                fi_val_i  = pol[0] ? fi_mask_i : '0;
                #5;
                if (b < NB) begin
                    got = good_ns;
                    got[b] = pol[0];
                    chk_alarm("R7 next-state stuck", got != good_ns);
                    chk("R9 outputs untouched", {4'd0, out_o}, {4'd0, good_ow});
                end else begin
                    got = good_ow;
                    got[b-NB] = pol[0];
                    chk("R9 forced output", {4'd0, out_o}, {4'd0, got});
                    chk_alarm("R8 output stuck", got != good_ow);
                end
                #2;
                fi_mask_i = '0;
                @(posedge clk_i);
                m_st = nxt_t[m_st][x_i];
                @(negedge clk_i);
            end
        end
    endtask

    // forced illegal state captured, then decoded by its 1 bits
    task automatic t_cover();
        do_reset();
        x_i = 1'b0;
        fi_mask_i = FW'(4'hF);
        fi_val_i  = FW'(4'b0011);
        #5;
        chk_alarm("R7 forced 0011", 1'b1);
        @(posedge clk_i);
        @(negedge clk_i);
        fi_mask_i = '0;
        x_i = 1'b0;
        #5;
        chk("R10 covered states ORed", {4'd0, out_o}, 8'b0000_1110);
        chk_alarm("R10 covered alarm", 1'b1);
        do_reset();
        fi_mask_i = FW'(4'hF);
        fi_val_i  = '0;
        @(posedge clk_i);
        @(negedge clk_i);
        fi_mask_i = '0;
        x_i = 1'b1;
        #5;
        chk("R10 empty state output", {4'd0, out_o}, 8'b0000_0000);
        chk_alarm("R10 empty alarm", 1'b1);
        do_reset();
        step(1'b1, "R1 R9 recovery after reset");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        nxt_t[0][0] = 0; nxt_t[0][1] = 1; info_t[0][0] = 2'b00; info_t[0][1] = 2'b01;
        nxt_t[1][0] = 2; nxt_t[1][1] = 0; info_t[1][0] = 2'b10; info_t[1][1] = 2'b01;
        nxt_t[2][0] = 3; nxt_t[2][1] = 2; info_t[2][0] = 2'b11; info_t[2][1] = 2'b00;
        nxt_t[3][0] = 0; nxt_t[3][1] = 1; info_t[3][0] = 2'b10; info_t[3][1] = 2'b11;
        code_t[0] = 4'b0001; code_t[1] = 4'b0010; code_t[2] = 4'b0100; code_t[3] = 4'b1000;
        t_reset();
        t_walk();
        t_random();
        t_faults();
        t_cover();
        finish_run();
    end

endmodule